// File: doc/BRIEF.md
# Power-Management Event Release Controller

This block is a small register file on a byte-wide I/O bus. It carries a two-way release handshake between operating-system power-management software and platform firmware. Each side has a write-only release bit. Writing 1 to it raises a sticky status flag that belongs to the other side. The flag stays set until its owner writes 1 to it.

Each status flag is qualified by an enable. A global routing mode then steers the flag to one of two level interrupts:

- the system-management interrupt (`smi`), which firmware services;
- the system-control interrupt (`sci`), which the OS services.

The block also latches a 3-bit sleep-type field. A self-clearing go bit turns that field into a one-cycle sleep request. Reserved sleep encodings are refused. A bus-master wake option produces a one-cycle wake pulse when a bus master asks for the bus while the CPU sits in the deepest idle state.

Register layout (byte offsets):

| Offset | Contents |
|--------|----------|
| 0 | control: bit0 routing mode, bit1 bus-master wake enable, bit2 OS release (write-only), bits 5:3 sleep type, bit6 sleep go (write-only) |
| 1 | firmware status, bit0 |
| 2 | firmware control: bit0 firmware enable, bit1 firmware release (write-only) |
| 3 | global status, bit0 |
| 4 | global enable, bit0 |

Offsets 5 to 7 are unused. Writes to them are ignored and reads return 0.

Top module: `pmRelCtl`

## Requirements
- R1: Writing offset 0 with bit2 = 1 sets the firmware status flag, which offset 1 bit0 reads as 1 after that write.
- R2: Writing offset 2 with bit1 = 1 sets the global status flag, which offset 3 bit0 reads as 1 after that write.
- R3: The OS release bit (offset 0 bit2), the sleep go bit (offset 0 bit6) and the firmware release bit (offset 2 bit1) always read as 0.
- R4: Writing 1 to bit0 of offset 1 or offset 3 clears that status flag. Writing 0 there leaves it unchanged.
- R5: With routing mode 0, `smi` is high exactly while (firmware status AND firmware enable) OR (global status AND global enable) holds, and `sci` stays low.
- R6: With routing mode 1, `sci` is high exactly while global status AND global enable holds. In this mode `smi` is high exactly while firmware status AND firmware enable holds.
- R7: A write to offset 0 with bit6 = 1 and a sleep type in 000..101 asserts `sleepReq` for exactly the one cycle after the write. During that cycle `sleepTypeOut` equals the written type. Sleep types: 000 full on, 001 to 100 sleep levels 1 to 4, 101 soft off.
- R8: A go write whose sleep type is 110 or 111 produces no `sleepReq`. The sleep-type field is still stored and reads back.
- R9: When bus-master wake (offset 0 bit1) is 1, the first cycle in which `cpuInC3` and `bmReq` are both high yields a one-cycle `wakePulse` in the next cycle. The pulse does not repeat while the condition is held, and no pulse occurs while the enable is 0.
- R10: After reset every register reads 00h and all outputs are low. Reserved bits and unused offsets always read 0.
- R11: The interrupt outputs are levels: once software clears the qualifying status flag, the output drops in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busAddr | input | ADDR_W | Register offset for write and read |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| cpuInC3 | input | 1 | CPU is in the deepest idle state |
| bmReq | input | 1 | Bus-master request |
| smi | output | 1 | System-management interrupt level |
| sci | output | 1 | System-control interrupt level |
| sleepReq | output | 1 | One-cycle sleep request |
| sleepTypeOut | output | 3 | Sleep type captured with the request |
| wakePulse | output | 1 | One-cycle wake to full-on request |

## Verification
The main check is a random mix of writes over all eight offsets with random data bytes. Because the data is random, release bits and clear bits frequently arrive together with changes to the mode and enable bits. After every write, all eight offsets are read back and both interrupt levels are compared with a bench model. This separates the routing of the two modes and shows whether status sticks through writes of 0. Directed cases cover the following:

- each release followed by a clear, which isolates how the level interrupts fall;
- go writes with all eight sleep types, which separates valid types from reserved ones;
- holding and re-raising the bus-master condition with the wake enable both off and on, which separates edge from level behaviour.

// File: rtl/pmRelPkg.sv
package pmRelPkg;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_FWSTS  = 1;
  localparam int OFS_FWCTL  = 2;
  localparam int OFS_GBLSTS = 3;
  localparam int OFS_GBLEN  = 4;

  localparam int BIT_MODE   = 0;
  localparam int BIT_BMWAKE = 1;
  localparam int BIT_OSREL  = 2;
  localparam int BIT_TYPELO = 3;
  localparam int BIT_GO     = 6;
  localparam int BIT_FWEN   = 0;
  localparam int BIT_FWREL  = 1;

  localparam logic [2:0] SLP_FIRST_RSVD = 3'd6;

  // event index: 0 = firmware-bound, 1 = OS-bound
  localparam int NUM_EVT = 2;
  localparam int EVT_FW  = 0;
  localparam int EVT_GBL = 1;

  typedef struct packed {
    logic wrCtrl;
    logic wrFwCtl;
    logic wrGblEn;
    logic clrFw;
    logic clrGbl;
    logic osRel;
    logic fwRel;
    logic sleepGo;
  } pmStrobes_t;
endpackage

// File: rtl/pmRelControl.sv
module pmRelControl
  import pmRelPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output pmStrobes_t        stb
);
  logic hitCtrl, hitFwSts, hitFwCtl, hitGblSts, hitGblEn;
  logic [2:0] wrType;
  logic typeValid;

  always_comb begin
    hitCtrl   = busWr && (busAddr == ADDR_W'(OFS_CTRL));
    hitFwSts  = busWr && (busAddr == ADDR_W'(OFS_FWSTS));
    hitFwCtl  = busWr && (busAddr == ADDR_W'(OFS_FWCTL));
    hitGblSts = busWr && (busAddr == ADDR_W'(OFS_GBLSTS));
    hitGblEn  = busWr && (busAddr == ADDR_W'(OFS_GBLEN));
    wrType    = busWrData[BIT_TYPELO +: 3];
    typeValid = (wrType < SLP_FIRST_RSVD);
  end

  always_comb begin
    stb         = '0;
    stb.wrCtrl  = hitCtrl;
    stb.wrFwCtl = hitFwCtl;
    stb.wrGblEn = hitGblEn;
    stb.clrFw   = hitFwSts && busWrData[0];
    stb.clrGbl  = hitGblSts && busWrData[0];
    stb.osRel   = hitCtrl && busWrData[BIT_OSREL];
    stb.fwRel   = hitFwCtl && busWrData[BIT_FWREL];
    stb.sleepGo = hitCtrl && busWrData[BIT_GO] && typeValid;
  end
endmodule

// File: rtl/pmRelDatapath.sv
module pmRelDatapath
  import pmRelPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmStrobes_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              cpuInC3,
  input  logic              bmReq,
  output logic [DATA_W-1:0] rdData,
  output logic              smi,
  output logic              sci,
  output logic              sleepReq,
  output logic [2:0]        sleepTypeOut,
  output logic              wakePulse,
  output logic              stsFw,
  output logic              stsGbl,
  output logic              modeSci,
  output logic              enGbl
);
  logic       sciModeQ, bmWakeEnQ, fwEnQ, gblEnQ;
  logic [2:0] sleepTypeQ;
  logic       sleepReqQ;
  logic [2:0] sleepTypeOutQ;
  logic       bmCondQ, wakeQ, bmCond;

  logic [NUM_EVT-1:0] evtSet, evtClr, evtEn, evtSts, evtQual, evtToSci;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sciModeQ   <= 1'b0;
      bmWakeEnQ  <= 1'b0;
      sleepTypeQ <= 3'd0;
      fwEnQ      <= 1'b0;
      gblEnQ     <= 1'b0;
    end else begin
      if (stb.wrCtrl) begin
        sciModeQ   <= wrData[BIT_MODE];
        bmWakeEnQ  <= wrData[BIT_BMWAKE];
        sleepTypeQ <= wrData[BIT_TYPELO +: 3];
      end
      if (stb.wrFwCtl) fwEnQ  <= wrData[BIT_FWEN];
      if (stb.wrGblEn) gblEnQ <= wrData[0];
    end
  end

  // cross-coupled release events
  always_comb begin
    evtSet[EVT_FW]    = stb.osRel;
    evtClr[EVT_FW]    = stb.clrFw;
    evtEn[EVT_FW]     = fwEnQ;
    evtToSci[EVT_FW]  = 1'b0;
    evtSet[EVT_GBL]   = stb.fwRel;
    evtClr[EVT_GBL]   = stb.clrGbl;
    evtEn[EVT_GBL]    = gblEnQ;
    evtToSci[EVT_GBL] = sciModeQ;
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : gEvt
    logic stsQ;
    always_ff @(posedge clk) begin
      if (!rstN)            stsQ <= 1'b0;
      else if (evtSet[e])   stsQ <= 1'b1;
      else if (evtClr[e])   stsQ <= 1'b0;
    end
    assign evtSts[e]  = stsQ;
    assign evtQual[e] = stsQ & evtEn[e];
  end

  assign smi = |(evtQual & ~evtToSci);
  assign sci = |(evtQual & evtToSci);

  // sleep request strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepReqQ     <= 1'b0;
      sleepTypeOutQ <= 3'd0;
    end else begin
      sleepReqQ <= stb.sleepGo;
      if (stb.sleepGo) sleepTypeOutQ <= wrData[BIT_TYPELO +: 3];
    end
  end
  assign sleepReq     = sleepReqQ;
  assign sleepTypeOut = sleepTypeOutQ;

  // bus-master wake edge
  assign bmCond = bmWakeEnQ & cpuInC3 & bmReq;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bmCondQ <= 1'b0;
      wakeQ   <= 1'b0;
    end else begin
      bmCondQ <= bmCond;
      wakeQ   <= bmCond & ~bmCondQ;
    end
  end
  assign wakePulse = wakeQ;

  // read mux
  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(OFS_CTRL): begin
        rdData[BIT_MODE]         = sciModeQ;
        rdData[BIT_BMWAKE]       = bmWakeEnQ;
        rdData[BIT_TYPELO +: 3]  = sleepTypeQ;
      end
      ADDR_W'(OFS_FWSTS):  rdData[0] = evtSts[EVT_FW];
      ADDR_W'(OFS_FWCTL):  rdData[BIT_FWEN] = fwEnQ;
      ADDR_W'(OFS_GBLSTS): rdData[0] = evtSts[EVT_GBL];
      ADDR_W'(OFS_GBLEN):  rdData[0] = gblEnQ;
      default:             rdData = '0;
    endcase
  end

  assign stsFw   = evtSts[EVT_FW];
  assign stsGbl  = evtSts[EVT_GBL];
  assign modeSci = sciModeQ;
  assign enGbl   = gblEnQ;

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[DATA_W-1:BIT_GO]};
endmodule

// File: rtl/pmRelCtl.sv
module pmRelCtl
  import pmRelPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              cpuInC3,
  input  logic              bmReq,
  output logic              smi,
  output logic              sci,
  output logic              sleepReq,
  output logic [2:0]        sleepTypeOut,
  output logic              wakePulse
);
  pmStrobes_t stb;
  logic stsFw, stsGbl, modeSci, enGbl;

  pmRelControl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData), .stb(stb)
  );

  pmRelDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .rdAddr(busAddr),
    .cpuInC3(cpuInC3), .bmReq(bmReq), .rdData(busRdData),
    .smi(smi), .sci(sci), .sleepReq(sleepReq), .sleepTypeOut(sleepTypeOut),
    .wakePulse(wakePulse), .stsFw(stsFw), .stsGbl(stsGbl),
    .modeSci(modeSci), .enGbl(enGbl)
  );
endmodule

// File: rtl/pmRelCtl_chk.sv
module pmRelCtl_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              smi,
  input logic              sci,
  input logic              sleepReq,
  input logic              wakePulse,
  input logic              stsFw,
  input logic              stsGbl,
  input logic              modeSci,
  input logic              enGbl
);
  AST_OSREL_SETS_FW: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(0) && busWrData[2]) |=> stsFw); // R1
  AST_FWREL_SETS_GBL: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(2) && busWrData[1]) |=> stsGbl); // R2
  AST_RELEASE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(0)) |-> (!busRdData[2] && !busRdData[6])); // R3
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(1) && !busWrData[0] && stsFw) |=> stsFw); // R4
  AST_SCI_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    sci |-> (modeSci && stsGbl && enGbl)); // R6
  AST_SMI_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    smi |-> (stsFw || stsGbl)); // R5
  AST_SLEEP_FROM_GO: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> $past(busWr && busAddr == ADDR_W'(0) && busWrData[6])); // R7
  AST_RSVD_TYPE_NO_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(0) && busWrData[6] && busWrData[5:4] == 2'b11)
      |=> !sleepReq); // R8
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R9
endmodule

bind pmRelCtl pmRelCtl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .smi(smi), .sci(sci),
  .sleepReq(sleepReq), .wakePulse(wakePulse), .stsFw(stsFw),
  .stsGbl(stsGbl), .modeSci(modeSci), .enGbl(enGbl)
);

// File: tb/pmRelCtl_tb_top.sv
`timescale 1ns/1ps
module pmRelCtl_tb_top;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic cpuInC3 = 1'b0, bmReq = 1'b0;
  logic smi, sci, sleepReq, wakePulse;
  logic [2:0] sleepTypeOut;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // bench model
  logic mMode, mBm, mFwSts, mFwEn, mGblSts, mGblEn;
  logic [2:0] mType;

  always #2.5 clk = ~clk;

  pmRelCtl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .cpuInC3(cpuInC3),
    .bmReq(bmReq), .smi(smi), .sci(sci), .sleepReq(sleepReq),
    .sleepTypeOut(sleepTypeOut), .wakePulse(wakePulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input int a);
    case (a)
      0: return {2'b00, mType, 1'b0, mBm, mMode};
      1: return {7'd0, mFwSts};
      2: return {7'd0, mFwEn};
      3: return {7'd0, mGblSts};
      4: return {7'd0, mGblEn};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic expSmi();
    return (mFwSts & mFwEn) | (~mMode & mGblSts & mGblEn);
  endfunction

  function automatic logic expSci();
    return mMode & mGblSts & mGblEn;
  endfunction

  task automatic checkAll(input string tag);
    for (int a = 0; a < 8; a++) begin
      busAddr = ADDR_W'(a);
      #0.1;
      chk({tag, " read"}, busRdData, expRead(a));
    end
    chk({tag, " smi"}, smi, expSmi());
    chk({tag, " sci"}, sci, expSci());
  endtask

  task automatic doWrite(input int a, input logic [7:0] d);
    logic goExp;
    @(negedge clk);
    busWr = 1'b1; busAddr = ADDR_W'(a); busWrData = d;
    goExp = (a == 0) && d[6] && (d[5:3] < 3'd6);
    @(negedge clk);
    busWr = 1'b0;
    // R7 / R8: pulse visible in the cycle after the write
    chk(goExp ? "R7 sleepReq" : "R8 sleepReq idle", sleepReq, goExp);
    if (goExp) chk("R7 sleepTypeOut", sleepTypeOut, d[5:3]);
    case (a)
      0: begin mMode = d[0]; mBm = d[1]; mType = d[5:3]; if (d[2]) mFwSts = 1'b1; end
      1: if (d[0]) mFwSts = 1'b0;
      2: begin mFwEn = d[0]; if (d[1]) mGblSts = 1'b1; end
      3: if (d[0]) mGblSts = 1'b0;
      4: mGblEn = d[0];
      default: ;
    endcase
    @(negedge clk);
    chk("R7 sleepReq single cycle", sleepReq, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    {mMode, mBm, mFwSts, mFwEn, mGblSts, mGblEn} = '0;
    mType = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    checkAll("R10 reset");
    chk("R10 sleepReq", sleepReq, 1'b0);
    chk("R10 wakePulse", wakePulse, 1'b0);

    // R1, R5, R11: OS release to firmware in mode 0
    doWrite(2, 8'h01);
    doWrite(0, 8'h04);
    checkAll("R1 R5 os release");
    chk("R5 smi high", smi, 1'b1);
    doWrite(1, 8'h00);
    checkAll("R4 zero write keeps");
    doWrite(1, 8'h01);
    checkAll("R11 fw clear");
    chk("R11 smi dropped", smi, 1'b0);

    // R2, R6: firmware release to OS in mode 1
    doWrite(4, 8'h01);
    doWrite(0, 8'h01);
    doWrite(2, 8'h03);
    checkAll("R2 R6 fw release");
    chk("R6 sci high", sci, 1'b1);
    chk("R6 smi low", smi, 1'b0);
    doWrite(0, 8'h00);
    checkAll("R5 mode0 routes gbl to smi");
    doWrite(3, 8'h01);
    checkAll("R11 gbl clear");

    // R3: release bits read zero
    doWrite(0, 8'hFF);
    checkAll("R3 R10 all ones ctrl");
    doWrite(2, 8'hFF);
    checkAll("R3 fwctl all ones");

    // R7 / R8: every sleep type with go
    for (int t = 0; t < 8; t++) begin
      doWrite(0, 8'(8'h40 | (t << 3)));
      checkAll("R8 type stored");
    end

    // R9: bus-master wake
    doWrite(0, 8'h00);
    @(negedge clk); cpuInC3 = 1'b1; bmReq = 1'b1;
    @(negedge clk); chk("R9 no wake when disabled", wakePulse, 1'b0);
    cpuInC3 = 1'b0; bmReq = 1'b0;
    doWrite(0, 8'h02);
    @(negedge clk); cpuInC3 = 1'b1; bmReq = 1'b1;
    @(negedge clk); chk("R9 wake pulse", wakePulse, 1'b1);
    @(negedge clk); chk("R9 wake single", wakePulse, 1'b0);
    @(negedge clk); chk("R9 held no repeat", wakePulse, 1'b0);
    cpuInC3 = 1'b0;
    @(negedge clk); @(negedge clk); chk("R9 not in C3", wakePulse, 1'b0);
    cpuInC3 = 1'b1;
    @(negedge clk); chk("R9 re-raise", wakePulse, 1'b1);
    cpuInC3 = 1'b0; bmReq = 1'b0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [7:0] d;
      a = $urandom_range(0, 7);
      d = 8'($urandom);
      if (a == 1 || a == 3) d[0] = ($urandom_range(0, 3) == 0);
      doWrite(a, d);
      checkAll("R1 R2 R4 R5 R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule